// File: doc/BRIEF.md
# Reference-Gated Frequency Lock Monitor

This block decides whether a recovered clock runs at the frequency it should, measured against the reference clock that runs the block. A divided copy of the recovered clock arrives as an asynchronous level. A two-flop synchronizer brings it into the reference domain, and its rising edges are counted over a gate of `2^GATE_LOG2` reference cycles.

At the end of each gate, the edge count is compared with the nominal count `2^(GATE_LOG2-RATIO_LOG2)`. The absolute difference is the frequency error in counts. The loss-of-lock state uses two thresholds. It clears only when the error is small, and it returns only when the error is large. When lock is lost, the block emits a one-cycle restart pulse so that the acquisition loop starts again from the bottom of its range.

A sticky fault bit records every loss of lock. Software clears it by setting and then dropping a clear control. An output-select control chooses what the lock pin shows: the live state or the sticky record. While the reference comparison is enabled, an output tells the neighbouring harmonic checker to stand down.

Top module: `freq_lock_monitor`

## Requirements
- R1: While unlocked and enabled, a gate result with error at or below `LOCK_THR` counts clears the live loss-of-lock state. The error is |rising edges in the gate − 2^(GATE_LOG2−RATIO_LOG2)|.
- R2: A gate result whose error is above `LOCK_THR` and not above `UNLOCK_THR` leaves the live state as it was, whether locked or unlocked.
- R3: While locked and enabled, a gate result with error above `UNLOCK_THR` sets the live loss-of-lock state. In the same cycle, `restart_o` is high for exactly one cycle. `restart_o` is never high at any other time.
- R4: While `ref_mode_en_i` is 0, the gate counters are held clear and the live state does not change.
- R5: The sticky bit `sticky_o` goes to 1 in the cycle the live state goes from locked to unlocked. It stays 1 after lock returns.
- R6: The sticky bit clears only in the cycle after `sticky_clr_i` goes from 1 to 0. Holding `sticky_clr_i` at 1 does not clear it. A new loss of lock in the same cycle wins over the clear.
- R7: When `pin_sticky_sel_i` is 1, `lol_o` shows the sticky bit. When it is 0, `lol_o` shows the live loss-of-lock state.
- R8: `harm_dis_o` is 1 exactly while `ref_mode_en_i` is 1.
- R9: After reset, the live state is unlocked (`lol_o` = 1 with select 0), `sticky_o` = 0, `restart_o` = 0, and the counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_div_i | input | 1 | Divided recovered clock, asynchronous |
| ref_mode_en_i | input | 1 | Enables the lock-to-reference comparison |
| sticky_clr_i | input | 1 | Sticky clear control; a 1 then a 0 clears the sticky bit |
| pin_sticky_sel_i | input | 1 | 1: lock pin shows sticky bit; 0: live state |
| lol_o | output | 1 | Loss-of-lock pin |
| sticky_o | output | 1 | Sticky loss-of-lock status |
| restart_o | output | 1 | One-cycle acquisition restart pulse |
| harm_dis_o | output | 1 | Disable request for the harmonic checker |

## Verification
The bench builds the block with a 256-cycle gate, a nominal count of 64 edges, `LOCK_THR` = 2 and `UNLOCK_THR` = 6. This makes one gate last a few hundred cycles, so many lock and unlock episodes fit in one run. The bench drives recovered clock periods of 3, 4 and 5 reference cycles, plus a 4/4/4/5 mix. These place the error near 0, inside the hysteresis band (about 4), and well beyond it (13 slow, 21 fast). That margin allows for the one-edge uncertainty at gate boundaries.

// File: rtl/flm_pkg.sv
package flm_pkg;
    // Register image of the lock decision stage
    typedef struct packed {
        logic unl;       // live loss-of-lock
        logic sticky;    // recorded loss-of-lock
        logic restart;   // acquisition restart pulse
        logic clr_prev;  // last sampled clear control
    } hyst_t;
endpackage

// File: rtl/flm_sync_edge.sv
module flm_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.s3;

    // R1
    no_double_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/flm_window.sv
module flm_window #(
    parameter int GATE_LOG2  = 16,
    parameter int RATIO_LOG2 = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 edge_i,
    output logic                 meas_v_o,
    output logic [GATE_LOG2-1:0] err_o
);
    localparam int W = GATE_LOG2;
    localparam logic [W:0] EXP_V   = (W+1)'(1) << (GATE_LOG2 - RATIO_LOG2);
    localparam logic [W:0] HALF_V  = (W+1)'(1) << (GATE_LOG2 - 1);

    typedef struct packed {
        logic [W-1:0] gate;
        logic [W-1:0] cnt;
        logic [W-1:0] err;
        logic         valid;
    } win_t;

    win_t w_d, w_q;
    logic [W:0] total;
    logic [W:0] diff;

    always_comb begin
        w_d       = w_q;
        w_d.valid = 1'b0;
        total     = {1'b0, w_q.cnt} + (W+1)'(edge_i);
        diff      = (total >= EXP_V) ? (total - EXP_V) : (EXP_V - total);
        if (!en_i) begin
            w_d.gate = '0;
            w_d.cnt  = '0;
        end else if (w_q.gate == '1) begin
            w_d.err   = diff[W-1:0];
            w_d.valid = 1'b1;
            w_d.cnt   = '0;
            w_d.gate  = '0;
        end else begin
            w_d.cnt  = total[W-1:0];
            w_d.gate = w_q.gate + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign meas_v_o = w_q.valid;
    assign err_o    = w_q.err;

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, w_q.cnt} <= HALF_V);
    // R4
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (w_q.gate == '0 && w_q.cnt == '0 && !meas_v_o));
endmodule

// File: rtl/flm_hyst.sv
module flm_hyst
    import flm_pkg::*;
#(
    parameter int EW         = 16,
    parameter int LOCK_THR   = 16,
    parameter int UNLOCK_THR = 65
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          meas_v_i,
    input  logic [EW-1:0] err_i,
    input  logic          clr_i,
    input  logic          pin_sel_i,
    output logic          lol_o,
    output logic          sticky_o,
    output logic          restart_o
);
    localparam logic [EW-1:0] LOCK_V   = EW'(LOCK_THR);
    localparam logic [EW-1:0] UNLOCK_V = EW'(UNLOCK_THR);

    hyst_t h_d, h_q;

    always_comb begin
        h_d          = h_q;
        h_d.restart  = 1'b0;
        h_d.clr_prev = clr_i;
        if (en_i && meas_v_i) begin
            if (h_q.unl && err_i <= LOCK_V) begin
                h_d.unl = 1'b0;
            end else if (!h_q.unl && err_i > UNLOCK_V) begin
                h_d.unl     = 1'b1;
                h_d.restart = 1'b1;
            end
        end
        if (h_q.clr_prev && !clr_i) h_d.sticky = 1'b0;
        if (h_d.restart)            h_d.sticky = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '{unl: 1'b1, sticky: 1'b0, restart: 1'b0, clr_prev: 1'b0};
        else        h_q <= h_d;
    end

    logic unl_q;
    assign unl_q     = h_q.unl;
    assign sticky_o  = h_q.sticky;
    assign restart_o = h_q.restart;
    assign lol_o     = pin_sel_i ? h_q.sticky : h_q.unl;

    // R1
    lock_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unl_q) |-> $past(en_i && meas_v_i && err_i <= LOCK_V));
    // R2
    lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unl_q) |-> $past(en_i && meas_v_i && err_i > UNLOCK_V));
    // R3
    restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> (unl_q && !$past(unl_q)));
    // R4
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> $stable(unl_q));
    // R5
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unl_q) |-> sticky_o);
endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor #(
    parameter int GATE_LOG2  = 16,
    parameter int RATIO_LOG2 = 2,
    parameter int LOCK_THR   = 16,
    parameter int UNLOCK_THR = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vco_div_i,
    input  logic ref_mode_en_i,
    input  logic sticky_clr_i,
    input  logic pin_sticky_sel_i,
    output logic lol_o,
    output logic sticky_o,
    output logic restart_o,
    output logic harm_dis_o
);
    logic                 vco_rise;
    logic                 meas_v;
    logic [GATE_LOG2-1:0] err;

    flm_sync_edge u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (vco_div_i),
        .rise_o  (vco_rise)
    );

    flm_window #(
        .GATE_LOG2  (GATE_LOG2),
        .RATIO_LOG2 (RATIO_LOG2)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (ref_mode_en_i),
        .edge_i   (vco_rise),
        .meas_v_o (meas_v),
        .err_o    (err)
    );

    flm_hyst #(
        .EW         (GATE_LOG2),
        .LOCK_THR   (LOCK_THR),
        .UNLOCK_THR (UNLOCK_THR)
    ) u_hyst (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (ref_mode_en_i),
        .meas_v_i  (meas_v),
        .err_i     (err),
        .clr_i     (sticky_clr_i),
        .pin_sel_i (pin_sticky_sel_i),
        .lol_o     (lol_o),
        .sticky_o  (sticky_o),
        .restart_o (restart_o)
    );

    assign harm_dis_o = ref_mode_en_i;

    // R8
    harm_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_mode_en_i) |-> harm_dis_o);
endmodule

// File: tb/tb_freq_lock_monitor.sv
module tb_freq_lock_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vco_div = 1'b0;
    logic mode_en = 1'b0;
    logic clr = 1'b0;
    logic sel = 1'b0;
    logic lol, sticky, restart, harm;

    int tests = 0;
    int fails = 0;
    int restarts = 0;
    int vco_mode = 0;  // 0 idle, 1 period 4, 2 period 5, 3 period 3, 4 mix 4/4/4/5
    bit done = 0;

    always #4 clk = ~clk;

    freq_lock_monitor #(
        .GATE_LOG2  (8),
        .RATIO_LOG2 (2),
        .LOCK_THR   (2),
        .UNLOCK_THR (6)
    ) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .vco_div_i        (vco_div),
        .ref_mode_en_i    (mode_en),
        .sticky_clr_i     (clr),
        .pin_sticky_sel_i (sel),
        .lol_o            (lol),
        .sticky_o         (sticky),
        .restart_o        (restart),
        .harm_dis_o       (harm)
    );

    always @(negedge clk) if (rst_n && restart) restarts++;

    // Divided recovered clock generator
    initial begin
        int k;
        int p;
        k = 0;
        forever begin
            case (vco_mode)
                1: p = 4;
                2: p = 5;
                3: p = 3;
                4: begin p = (k == 3) ? 5 : 4; k = (k + 1) % 4; end
                default: p = 0;
            endcase
            if (p == 0) begin
                @(negedge clk);
            end else begin
                vco_div = 1'b1;
                @(negedge clk);
                vco_div = 1'b0;
                repeat (p - 1) @(negedge clk);
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (800) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 lol after reset", lol, 1'b1);
        chk("R9 sticky after reset", sticky, 1'b0);
        chk("R9 restart after reset", restart, 1'b0);
        chk("R8 harm off while disabled", harm, 1'b0);
    endtask

    task automatic t_disabled();
        vco_mode = 1;
        settle();
        chk("R4 no lock while disabled", lol, 1'b1);
        chk_int("R4 no restart while disabled", restarts, 0);
    endtask

    task automatic t_lock();
        mode_en = 1'b1;
        @(negedge clk);
        chk("R8 harm on when enabled", harm, 1'b1);
        settle();
        chk("R1 lock on good clock", lol, 1'b0);
        chk("R5 sticky stays low on first lock", sticky, 1'b0);
    endtask

    task automatic t_band_locked();
        vco_mode = 4;
        settle();
        chk("R2 band keeps lock", lol, 1'b0);
        chk_int("R2 no restart in band", restarts, 0);
    endtask

    task automatic t_slow();
        vco_mode = 2;
        settle();
        chk("R3 unlock on slow clock", lol, 1'b1);
        chk_int("R3 single restart pulse", restarts, 1);
        chk("R5 sticky set", sticky, 1'b1);
    endtask

    task automatic t_band_unlocked();
        vco_mode = 4;
        settle();
        chk("R2 band keeps unlock", lol, 1'b1);
    endtask

    task automatic t_relock();
        vco_mode = 1;
        settle();
        chk("R1 relock", lol, 1'b0);
        chk("R5 sticky holds after relock", sticky, 1'b1);
    endtask

    task automatic t_pin_sel();
        sel = 1'b1;
        @(negedge clk);
        chk("R7 pin mirrors sticky", lol, 1'b1);
    endtask

    task automatic t_clear();
        clr = 1'b1;
        repeat (5) @(negedge clk);
        chk("R6 held clear does not clear", sticky, 1'b1);
        clr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 clear on 1 then 0", sticky, 1'b0);
        chk("R7 pin follows cleared sticky", lol, 1'b0);
    endtask

    task automatic t_fast();
        vco_mode = 3;
        settle();
        chk("R7 pin mirrors new sticky", lol, 1'b1);
        chk("R5 sticky set again", sticky, 1'b1);
        chk_int("R3 second restart", restarts, 2);
        sel = 1'b0;
        @(negedge clk);
        chk("R7 pin shows live state", lol, 1'b1);
    endtask

    task automatic t_freeze();
        mode_en = 1'b0;
        vco_mode = 1;
        settle();
        chk("R4 live state frozen when disabled", lol, 1'b1);
        chk("R8 harm off after disable", harm, 1'b0);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_lock();
        t_band_locked();
        t_slow();
        t_band_unlocked();
        t_relock();
        t_pin_sel();
        t_clear();
        t_fast();
        t_freeze();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule